// File: doc/BRIEF.md
# Trigger Event Tag Generator

This block turns each second-level trigger accept into a routing tag. An accept arrives as a one-cycle strobe that carries a vector of trigger bits and an event number. A programmable table holds one entry per trigger bit: a valid flag, an event type, a routing class and a target (segment or node) field. The block picks one table entry for the event and builds a tag from that entry's fields and the event number. Downstream bridges use the tag to decide where the event's data goes.

Finished tags are stored in a first-in first-out queue. The head tag is offered on a valid/ready stream and leaves the queue when the consumer accepts it. The queue occupancy drives a throttle line back to the first-level trigger, with hysteresis between a high mark and a low mark. If an accept arrives while the queue is full, the accept is lost and a sticky error flag latches.

There are two small state machines. The throttle machine has states `THR_OPEN` and `THR_HOLD`. Its transition *open-to-hold* is taken when the occupancy is at or above the high mark, and *hold-to-open* when it is at or below the low mark. The error machine has states `OVF_CLEAR` and `OVF_LATCHED`. Its transition *latch* is taken when an accept is dropped, and *release* when a clear arrives in a cycle with no drop.

Top module: `trig_tag_gen`

## Requirements
- R1: After reset the queue is empty (`tag_valid`=0), `l1_disable`=0, `ovf_err`=0, and every table entry is invalid.
- R2: When `tbl_we` is high, the entry at `tbl_addr` takes `tbl_valid`, `tbl_type`, `tbl_cls` and `tbl_tgt` at the clock edge. A later accept whose only selecting bit is that index yields a tag with exactly those type, class and target values.
- R3: When several trigger bits are set, the lowest-numbered set bit whose entry is valid selects the type, class and target.
- R4: If no set bit has a valid entry (including an all-zero bit vector), the tag takes type 0, class generic (2'd0) and target 0. Class codes are: generic 2'd0 (any segment or node), targeted 2'd1 (a specific segment or node), special 2'd2 (diagnostic or broadcast).
- R5: Each tag carries the event number of its accept, unchanged.
- R6: Tags leave in the order of their accepts. While `tag_valid` is high and `tag_ready` is low, the head tag and `tag_valid` hold steady.
- R7: A tag is removed when `tag_valid` and `tag_ready` are both high at a clock edge. An accept is stored at the edge where `trig_stb` is high and the queue is not full. With QDEPTH=16, the first stored tag is visible the cycle after its accept.
- R8: `l1_disable` rises one cycle after the occupancy reaches HI_MARK (12). It then stays high until one cycle after the occupancy has dropped to LO_MARK (8) or lower.
- R9: An accept that arrives while the queue holds QDEPTH entries is discarded, even if a tag is popped in the same cycle. It leaves the queue contents and order untouched, and `ovf_err` goes high at that edge.
- R10: `ovf_err` stays high until `ovf_clr` is sampled high in a cycle with no new drop. A drop in the same cycle as `ovf_clr` keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_stb | input | 1 | Accept strobe, one cycle per event |
| trig_bits | input | NBITS | Trigger bits of the accept |
| trig_evnum | input | EVN_W | Event number of the accept |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | $clog2(NBITS) | Table entry index (trigger bit number) |
| tbl_valid | input | 1 | Entry valid flag to write |
| tbl_type | input | TYPE_W | Event type to write |
| tbl_cls | input | 2 | Routing class to write |
| tbl_tgt | input | TGT_W | Target segment/node to write |
| ovf_clr | input | 1 | Clears the overflow flag |
| tag_ready | input | 1 | Consumer can accept the head tag |
| tag_valid | output | 1 | Head tag present |
| tag_evnum | output | EVN_W | Head tag event number |
| tag_type | output | TYPE_W | Head tag event type |
| tag_cls | output | 2 | Head tag routing class |
| tag_tgt | output | TGT_W | Head tag target |
| l1_disable | output | 1 | Throttle to first-level trigger |
| ovf_err | output | 1 | Sticky dropped-accept flag |

## Verification
The assertions assume the following about the inputs:
- `tag_ready` is an ordinary level, and a consumer takes the head tag only while `tag_valid` is high.
- The table is not rewritten in the same cycle as an accept that depends on the entry being written.

The stimulus keeps within these limits. It drives every input on the falling edge, never overlaps a table write with an accept, and holds `tag_ready` low except for single-cycle pops.

The sweep covers all 256 trigger-bit patterns against a table in which some entries are valid and some are not. Fill and drain runs then walk the occupancy through both throttle marks and into the full condition.

// File: rtl/trig_tag_pkg.sv
package trig_tag_pkg;
    typedef enum logic [1:0] {
        CLS_GENERIC  = 2'd0,
        CLS_TARGETED = 2'd1,
        CLS_SPECIAL  = 2'd2
    } route_cls_e;

    typedef enum logic {
        THR_OPEN = 1'b0,
        THR_HOLD = 1'b1
    } thr_state_e;

    typedef enum logic {
        OVF_CLEAR   = 1'b0,
        OVF_LATCHED = 1'b1
    } ovf_state_e;
endpackage

// File: rtl/tag_lut.sv
module tag_lut #(
    parameter int NBITS  = 8,
    parameter int TYPE_W = 4,
    parameter int TGT_W  = 4,
    localparam int AW    = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic              wvalid,
    input  logic [TYPE_W-1:0] wtype,
    input  logic [1:0]        wcls,
    input  logic [TGT_W-1:0]  wtgt,
    input  logic [NBITS-1:0]  bits,
    output logic [TYPE_W-1:0] lk_type,
    output logic [1:0]        lk_cls,
    output logic [TGT_W-1:0]  lk_tgt
);
    import trig_tag_pkg::*;

    logic [NBITS-1:0]  ent_valid;
    logic [TYPE_W-1:0] ent_type [NBITS];
    logic [1:0]        ent_cls  [NBITS];
    logic [TGT_W-1:0]  ent_tgt  [NBITS];

    for (genvar g = 0; g < NBITS; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[g] <= 1'b0;
                ent_type[g]  <= '0;
                ent_cls[g]   <= CLS_GENERIC;
                ent_tgt[g]   <= '0;
            end else if (we && (waddr == AW'(g))) begin
                ent_valid[g] <= wvalid;
                ent_type[g]  <= wtype;
                ent_cls[g]   <= wcls;
                ent_tgt[g]   <= wtgt;
            end
        end
    end

    logic [NBITS-1:0] hit;
    assign hit = bits & ent_valid;

    always_comb begin
        logic found;
        found   = 1'b0;
        lk_type = '0;
        lk_cls  = CLS_GENERIC;
        lk_tgt  = '0;
        for (int i = 0; i < NBITS; i++) begin
            if (!found && hit[i]) begin
                found   = 1'b1;
                lk_type = ent_type[i];
                lk_cls  = ent_cls[i];
                lk_tgt  = ent_tgt[i];
            end
        end
    end
endmodule

// File: rtl/tag_fifo.sv
module tag_fifo #(
    parameter int W     = 26,
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          wr_en, rd_en;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign wr_en = push && !full;
    assign rd_en = pop && !empty;
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_drop_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> full);

    assert_head_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !empty && !pop |=> !empty && $stable(dout));
endmodule

// File: rtl/throttle_fsm.sv
module throttle_fsm #(
    parameter int CW      = 5,
    parameter int HI_MARK = 12,
    parameter int LO_MARK = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] occ,
    output logic          l1_disable
);
    import trig_tag_pkg::*;

    thr_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= THR_OPEN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            THR_OPEN: if (occ >= CW'(HI_MARK)) state_nx = THR_HOLD;
            THR_HOLD: if (occ <= CW'(LO_MARK)) state_nx = THR_OPEN;
        endcase
    end

    always_comb begin
        l1_disable = (state == THR_HOLD);
    end

    assert_disable_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !l1_disable && occ >= CW'(HI_MARK) |=> l1_disable);

    assert_disable_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        l1_disable && occ > CW'(LO_MARK) |=> l1_disable);
endmodule

// File: rtl/trig_tag_gen.sv
module trig_tag_gen #(
    parameter int NBITS   = 8,
    parameter int EVN_W   = 16,
    parameter int TYPE_W  = 4,
    parameter int TGT_W   = 4,
    parameter int QDEPTH  = 16,
    parameter int HI_MARK = 12,
    parameter int LO_MARK = 8,
    localparam int AW     = (NBITS > 1) ? $clog2(NBITS) : 1,
    localparam int TAG_W  = EVN_W + TYPE_W + 2 + TGT_W,
    localparam int CW     = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_stb,
    input  logic [NBITS-1:0]  trig_bits,
    input  logic [EVN_W-1:0]  trig_evnum,
    input  logic              tbl_we,
    input  logic [AW-1:0]     tbl_addr,
    input  logic              tbl_valid,
    input  logic [TYPE_W-1:0] tbl_type,
    input  logic [1:0]        tbl_cls,
    input  logic [TGT_W-1:0]  tbl_tgt,
    input  logic              ovf_clr,
    input  logic              tag_ready,
    output logic              tag_valid,
    output logic [EVN_W-1:0]  tag_evnum,
    output logic [TYPE_W-1:0] tag_type,
    output logic [1:0]        tag_cls,
    output logic [TGT_W-1:0]  tag_tgt,
    output logic              l1_disable,
    output logic              ovf_err
);
    import trig_tag_pkg::*;

    logic [TYPE_W-1:0] lk_type;
    logic [1:0]        lk_cls;
    logic [TGT_W-1:0]  lk_tgt;
    logic [TAG_W-1:0]  q_din, q_dout;
    logic              q_empty, q_full;
    logic [CW-1:0]     q_count;
    logic              drop;

    tag_lut #(.NBITS(NBITS), .TYPE_W(TYPE_W), .TGT_W(TGT_W)) u_lut (
        .clk(clk), .rst_n(rst_n),
        .we(tbl_we), .waddr(tbl_addr), .wvalid(tbl_valid),
        .wtype(tbl_type), .wcls(tbl_cls), .wtgt(tbl_tgt),
        .bits(trig_bits),
        .lk_type(lk_type), .lk_cls(lk_cls), .lk_tgt(lk_tgt)
    );

    assign q_din = {trig_evnum, lk_type, lk_cls, lk_tgt};

    tag_fifo #(.W(TAG_W), .DEPTH(QDEPTH)) u_q (
        .clk(clk), .rst_n(rst_n),
        .push(trig_stb), .din(q_din),
        .pop(tag_ready), .dout(q_dout),
        .empty(q_empty), .full(q_full), .count(q_count)
    );

    assign tag_valid = !q_empty;
    assign {tag_evnum, tag_type, tag_cls, tag_tgt} = q_dout;

    throttle_fsm #(.CW(CW), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_thr (
        .clk(clk), .rst_n(rst_n), .occ(q_count), .l1_disable(l1_disable)
    );

    ovf_state_e ovf_state, ovf_nx;
    assign drop = trig_stb && q_full;

    always_ff @(posedge clk) begin
        if (!rst_n) ovf_state <= OVF_CLEAR;
        else        ovf_state <= ovf_nx;
    end

    always_comb begin
        ovf_nx = ovf_state;
        unique case (ovf_state)
            OVF_CLEAR:   if (drop) ovf_nx = OVF_LATCHED;
            OVF_LATCHED: if (ovf_clr && !drop) ovf_nx = OVF_CLEAR;
        endcase
    end

    always_comb begin
        ovf_err = (ovf_state == OVF_LATCHED);
    end

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err && !ovf_clr |=> ovf_err);

    assert_drop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_stb && q_full |=> ovf_err);
endmodule

// File: tb/trig_tag_gen_tb.sv
module trig_tag_gen_tb;
    localparam int NB = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic trig_stb = 0;
    logic [NB-1:0] trig_bits = '0;
    logic [15:0] trig_evnum = '0;
    logic tbl_we = 0;
    logic [2:0] tbl_addr = '0;
    logic tbl_valid = 0;
    logic [3:0] tbl_type = '0;
    logic [1:0] tbl_cls = '0;
    logic [3:0] tbl_tgt = '0;
    logic ovf_clr = 0;
    logic tag_ready = 0;
    logic tag_valid;
    logic [15:0] tag_evnum;
    logic [3:0] tag_type;
    logic [1:0] tag_cls;
    logic [3:0] tag_tgt;
    logic l1_disable, ovf_err;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int occ = 0;
    bit dis_m = 0;

    bit       m_val [NB];
    int       m_type [NB], m_cls [NB], m_tgt [NB];

    always #10 clk = ~clk;

    trig_tag_gen u_dut (
        .clk(clk), .rst_n(rst_n), .trig_stb(trig_stb), .trig_bits(trig_bits),
        .trig_evnum(trig_evnum), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_valid(tbl_valid), .tbl_type(tbl_type), .tbl_cls(tbl_cls),
        .tbl_tgt(tbl_tgt), .ovf_clr(ovf_clr), .tag_ready(tag_ready),
        .tag_valid(tag_valid), .tag_evnum(tag_evnum), .tag_type(tag_type),
        .tag_cls(tag_cls), .tag_tgt(tag_tgt), .l1_disable(l1_disable),
        .ovf_err(ovf_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void expect_tag(input logic [NB-1:0] b,
                                       output int t, output int c, output int g);
        t = 0; c = 0; g = 0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (b[i] && m_val[i]) begin t = m_type[i]; c = m_cls[i]; g = m_tgt[i]; end
        end
    endfunction

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic push(input logic [NB-1:0] b, input int ev);
        trig_stb = 1; trig_bits = b; trig_evnum = 16'(ev);
        step();
        trig_stb = 0;
        if (occ < 16) occ++;
    endtask

    task automatic pop();
        tag_ready = 1;
        step();
        tag_ready = 0;
        if (occ > 0) occ--;
    endtask

    task automatic upd_dis();
        if (!dis_m && occ >= 12) dis_m = 1;
        else if (dis_m && occ <= 8) dis_m = 0;
    endtask

    task automatic check_head(input string req, input logic [NB-1:0] b, input int ev);
        int t, c, g;
        expect_tag(b, t, c, g);
        chk({req, " valid"}, int'(tag_valid), 1);
        chk({req, " evnum R5"}, int'(tag_evnum), ev & 16'hffff);
        chk({req, " type"}, int'(tag_type), t);
        chk({req, " class"}, int'(tag_cls), c);
        chk({req, " target"}, int'(tag_tgt), g);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            m_val[i] = 0; m_type[i] = 0; m_cls[i] = 0; m_tgt[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tag_valid", int'(tag_valid), 0);
        chk("R1 l1_disable", int'(l1_disable), 0);
        chk("R1 ovf_err", int'(ovf_err), 0);
        push(8'hff, 1);
        chk("R1 table invalid -> default type", int'(tag_type), 0);
        chk("R1 table invalid -> default class", int'(tag_cls), 0);
        pop();

        // R2 program table: bits 0,3,6 left invalid
        for (int i = 0; i < NB; i++) begin
            m_val[i] = (i % 3) != 0;
            m_type[i] = i + 3; m_cls[i] = i % 3; m_tgt[i] = 15 - i;
            tbl_we = 1; tbl_addr = 3'(i); tbl_valid = m_val[i];
            tbl_type = 4'(m_type[i]); tbl_cls = 2'(m_cls[i]); tbl_tgt = 4'(m_tgt[i]);
            step();
        end
        tbl_we = 0;
        push(8'h02, 77);
        chk("R2 single bit type", int'(tag_type), 4);
        chk("R2 single bit class", int'(tag_cls), 1);
        chk("R2 single bit target", int'(tag_tgt), 14);
        pop();

        // R3/R4/R5/R7 sweep over every trigger pattern
        for (int p = 0; p < 256; p++) begin
            push(8'(p), p * 37 + 5);
            check_head("R3 R4 sweep", 8'(p), p * 37 + 5);
            pop();
            chk("R7 removed after pop", int'(tag_valid), 0);
        end

        // R6 hold while not ready
        push(8'h24, 999);
        step(); step();
        check_head("R6 hold", 8'h24, 999);
        pop();

        // R7/R8 fill with throttle tracking
        for (int k = 0; k < 16; k++) begin
            push(8'(1 << (k % 8)), 100 + k);
            step(); upd_dis();
            chk("R8 disable fill", int'(l1_disable), int'(dis_m));
        end
        // R9 drop while full
        push(8'h04, 555);
        chk("R9 ovf set", int'(ovf_err), 1);
        step(); step();
        chk("R10 ovf sticky", int'(ovf_err), 1);
        // R9 drop also with pop in the same cycle
        trig_stb = 1; trig_bits = 8'h08; trig_evnum = 16'd556; tag_ready = 1;
        step();
        trig_stb = 0; tag_ready = 0; occ--;
        check_head("R9 queue after full push+pop", 8'(1 << 1), 101);
        // drain: R6 order, R9 dropped absent, R8 hysteresis
        for (int k = 1; k < 16; k++) begin
            check_head("R6 order", 8'(1 << (k % 8)), 100 + k);
            pop();
            step(); upd_dis();
            chk("R8 disable drain", int'(l1_disable), int'(dis_m));
        end
        chk("R9 dropped not queued", int'(tag_valid), 0);

        // R10 clear, then set-wins
        ovf_clr = 1; step(); ovf_clr = 0;
        chk("R10 cleared", int'(ovf_err), 0);
        for (int k = 0; k < 16; k++) push(8'h80, 200 + k);
        ovf_clr = 1;
        push(8'h80, 300);
        ovf_clr = 0;
        chk("R10 drop beats clear", int'(ovf_err), 1);
        ovf_clr = 1; step(); ovf_clr = 0;
        chk("R10 cleared again", int'(ovf_err), 0);
        for (int k = 0; k < 16; k++) begin
            check_head("R7 drain order", 8'h80, 200 + k);
            pop();
        end
        step(); step();
        chk("R8 released empty", int'(l1_disable), 0);
        chk("R7 empty", int'(tag_valid), 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule